// File: doc/BRIEF.md
# Zone Write Permission Filter

This block sits between a memory command decoder and a byte-wide nonvolatile array model. For each write request it decides, byte by byte, what is actually stored in one 32-byte user zone. The decoder opens a request with a one-cycle start pulse. The pulse carries the start address, the byte count, the protection mode of the target zone and a single permission bit. That bit already folds in every password and authentication check. The data bytes then follow on a valid strobe.

For each accepted byte the filter drives a read address and takes back the current array contents. It also reads the lock byte of the 8-byte page that holds the target. It then emits at most one registered write, carrying an address and a merged data value, and it sets a sticky reject flag when a byte is refused. Four protection modes are supported:

- **Open**: bytes are stored as given.
- **Clear-only**: bits may only fall from 1 to 0.
- **Lock-page**: one byte per request, gated by the in-memory lock byte of its 8-byte page.
- **Frozen**: nothing may be written.

Top module: `zone_write_filter`

## Requirements
- R1: While reset is asserted, and until the first request, `wr_en` and `reject` are 0.
- R2: In open mode (`cmd_mode` = 0), byte i of a request (i from 0 to `cmd_len`, so 1 to 16 bytes) is written unchanged to address {`cmd_addr`[6:4], (`cmd_addr`[3:0] + i) mod 16}. The address wraps inside the 16-byte page. `wr_en` is high in the cycle after the byte is accepted. Bytes beyond the count produce no write.
- R3: When `cmd_allow` is 0 at the start pulse, no byte of that request asserts `wr_en`, and every byte of it sets `reject`.
- R4: In frozen mode (`cmd_mode` = 3), no byte is written and every byte sets `reject`.
- R5: In clear-only mode (`cmd_mode` = 2), the stored value is the old array value ANDed with the new byte.
- R6: In lock-page mode (`cmd_mode` = 1), only the first byte of a request is considered. Later bytes are dropped without a write and without setting `reject`.
- R7: In lock-page mode, a byte at page offset n (n from 1 to 7) is written unchanged when bit n of the page's lock byte (offset 0) is 1. When that bit is 0, the byte is not written and `reject` is set.
- R8: In lock-page mode, a write to the lock byte itself stores old AND new when the lock byte's bit 0 is 1. When bit 0 is 0, the write is refused and `reject` is set.
- R9: `reject` stays high until the next start pulse and is 0 in the cycle after it. A byte strobe in the same cycle as a start pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that opens a request |
| cmd_addr | input | 7 | Start address: zone in [6:5], offset in [4:0] |
| cmd_len | input | 4 | Byte count minus one |
| cmd_mode | input | 2 | Zone protection mode: 0 open, 1 lock-page, 2 clear-only, 3 frozen |
| cmd_allow | input | 1 | Write permitted by the security checks |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| rd_addr | output | 7 | Address of the byte currently being filtered |
| rd_data | input | 8 | Array contents at `rd_addr` |
| lock_addr | output | 7 | Address of the lock byte of the current 8-byte page |
| lock_data | input | 8 | Array contents at `lock_addr` |
| wr_en | output | 1 | Array write enable |
| wr_addr | output | 7 | Array write address |
| wr_data | output | 8 | Merged value to store |
| reject | output | 1 | Sticky refusal flag for the current request |

## Verification
Open-mode writes are tried with a start near the top of a 16-byte page and with a full 16-byte burst. This separates correct in-page wrapping from a carry into the next page. Extra trailing bytes are sent to confirm that the count is honoured.

Clear-only writes go twice to the same bytes with different patterns. Only an AND with the stored value reproduces the second result.

Lock-page requests aim at locked and unlocked offsets, carry several bytes, and program the lock byte until its own bit 0 falls. This shows the page gating, the single-byte limit and the self-lock as separate effects.

Denied and frozen requests, together with a start pulse that overlaps a byte strobe, show that refusal leaves the array untouched and that `reject` persists only until the next request.

// File: rtl/zwf_pkg.sv
package zwf_pkg;
  typedef enum logic [1:0] {
    ZM_OPEN      = 2'd0,
    ZM_LOCKPAGE  = 2'd1,
    ZM_CLEARONLY = 2'd2,
    ZM_FROZEN    = 2'd3
  } zone_mode_e;
endpackage

// File: rtl/zwf_addr_gen.sv
module zwf_addr_gen #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int LOCK_W = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [PAGE_W-1:0] idx,
  output logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] lock
);
  logic [PAGE_W-1:0] off;

  // offset wraps inside the write page; upper bits never carry
  always_comb begin
    off  = base[PAGE_W-1:0] + idx;
    cur  = {base[ADDR_W-1:PAGE_W], off};
    lock = {cur[ADDR_W-1:LOCK_W], {LOCK_W{1'b0}}};
  end
endmodule

// File: rtl/zwf_byte_rule.sv
module zwf_byte_rule
  import zwf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOCK_W = 3
) (
  input  zone_mode_e        mode,
  input  logic              allow,
  input  logic              first,
  input  logic [LOCK_W-1:0] pofs,
  input  logic [DATA_W-1:0] old_v,
  input  logic [DATA_W-1:0] new_v,
  input  logic [DATA_W-1:0] lock_v,
  output logic              we,
  output logic [DATA_W-1:0] val,
  output logic              bad
);
  always_comb begin
    we  = 1'b0;
    val = new_v;
    bad = 1'b0;
    if (!allow) begin
      bad = 1'b1;
    end else begin
      unique case (mode)
        ZM_OPEN: we = 1'b1;
        ZM_CLEARONLY: begin
          we  = 1'b1;
          val = old_v & new_v;
        end
        ZM_FROZEN: bad = 1'b1;
        ZM_LOCKPAGE: begin
          if (first) begin
            if (pofs == '0) begin
              // the lock byte guards itself through its bit 0
              if (old_v[0]) begin
                we  = 1'b1;
                val = old_v & new_v;
              end else begin
                bad = 1'b1;
              end
            end else if (lock_v[pofs]) begin
              we = 1'b1;
            end else begin
              bad = 1'b1;
            end
          end
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/zone_write_filter.sv
module zone_write_filter
  import zwf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W-1:0] cmd_len,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_allow,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] lock_addr,
  input  logic [DATA_W-1:0] lock_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              reject
);
  localparam int LOCK_W = $clog2(DATA_W);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              act_q, act_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [PAGE_W-1:0] len_q, len_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  zone_mode_e        mode_q, mode_d;
  logic              allow_q, allow_d;
  logic              rej_q, rej_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  logic              take, rule_we, rule_bad;
  logic [DATA_W-1:0] rule_val;
  logic [ADDR_W-1:0] cur_addr, pg_lock_addr;

  zwf_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOCK_W(LOCK_W)) u_addr (
    .base (base_q),
    .idx  (idx_q),
    .cur  (cur_addr),
    .lock (pg_lock_addr)
  );

  zwf_byte_rule #(.DATA_W(DATA_W), .LOCK_W(LOCK_W)) u_rule (
    .mode   (mode_q),
    .allow  (allow_q),
    .first  (idx_q == '0),
    .pofs   (cur_addr[LOCK_W-1:0]),
    .old_v  (rd_data),
    .new_v  (byte_data),
    .lock_v (lock_data),
    .we     (rule_we),
    .val    (rule_val),
    .bad    (rule_bad)
  );

  assign take = byte_valid & act_q & ~cmd_start;

  always_comb begin
    act_d   = act_q;
    base_d  = base_q;
    len_d   = len_q;
    idx_d   = idx_q;
    mode_d  = mode_q;
    allow_d = allow_q;
    rej_d   = rej_q;
    we_d    = take & rule_we;
    if (cmd_start) begin
      act_d   = 1'b1;
      base_d  = cmd_addr;
      len_d   = cmd_len;
      idx_d   = '0;
      mode_d  = zone_mode_e'(cmd_mode);
      allow_d = cmd_allow;
      rej_d   = 1'b0;
    end else if (take) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == len_q) act_d = 1'b0;
      if (rule_bad) rej_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q   <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      mode_q  <= ZM_OPEN;
      allow_q <= 1'b0;
      rej_q   <= 1'b0;
      we_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      act_q   <= act_d;
      base_q  <= base_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      mode_q  <= mode_d;
      allow_q <= allow_d;
      rej_q   <= rej_d;
      we_q    <= we_d;
      if (take) begin
        wa_q <= cur_addr;
        wd_q <= rule_val;
      end
    end
  end

  assign rd_addr   = cur_addr;
  assign lock_addr = pg_lock_addr;
  assign wr_en     = we_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign reject    = rej_q;
endmodule

// File: rtl/zwf_checker.sv
module zwf_checker #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        cmd_mode,
  input logic              cmd_allow,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              reject
);
  logic [1:0]             c_mode;
  logic                   c_allow;
  logic [ADDR_W-PAGE_W-1:0] c_page;
  logic [1:0]             c_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mode  <= 2'd0;
      c_allow <= 1'b0;
      c_page  <= '0;
      c_cnt   <= 2'd0;
    end else if (cmd_start) begin
      c_mode  <= cmd_mode;
      c_allow <= cmd_allow;
      c_page  <= cmd_addr[ADDR_W-1:PAGE_W];
      c_cnt   <= 2'd0;
    end else if (wr_en && c_cnt != 2'd3) begin
      c_cnt <= c_cnt + 2'd1;
    end
  end

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr[ADDR_W-1:PAGE_W] == c_page); // R2
  AST_DENIED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> c_allow); // R3
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> c_mode != 2'd3); // R4
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_mode == 2'd2) |-> ((wr_data & ~$past(rd_data)) == '0)); // R5
  AST_ONE_LOCKPAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_mode == 2'd1) |-> c_cnt == 2'd0); // R6
  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !cmd_start) |=> reject); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !reject); // R9
endmodule

bind zone_write_filter zwf_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .cmd_addr  (cmd_addr),
  .cmd_mode  (cmd_mode),
  .cmd_allow (cmd_allow),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .reject    (reject)
);

// File: tb/zone_write_filter_tb.sv
module zone_write_filter_tb;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_start, cmd_allow, byte_valid;
  logic [6:0] cmd_addr;
  logic [3:0] cmd_len;
  logic [1:0] cmd_mode;
  logic [7:0] byte_data;
  logic [6:0] rd_addr, lock_addr, wr_addr;
  logic [7:0] rd_data, lock_data, wr_data;
  logic       wr_en, reject;

  always #4 clk = ~clk;

  zone_write_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_mode(cmd_mode), .cmd_allow(cmd_allow),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .lock_addr(lock_addr), .lock_data(lock_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .reject(reject)
  );

  // reference model state
  logic [7:0] mem [DEPTH];
  int   m_act, m_base, m_len, m_idx, m_mode, m_allow;
  logic exp_en, exp_rej;
  int   exp_a;
  logic [7:0] exp_d;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  assign rd_data   = mem[rd_addr];
  assign lock_data = mem[lock_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      m_act = 0; m_idx = 0; exp_en = 0; exp_rej = 0; exp_a = 0; exp_d = 0;
      m_base = 0; m_len = 0; m_mode = 0; m_allow = 0;
    end else begin
      exp_en = 0;
      if (cmd_start) begin
        m_act = 1; m_base = cmd_addr; m_len = cmd_len; m_idx = 0;
        m_mode = cmd_mode; m_allow = cmd_allow; exp_rej = 0;
      end else if (byte_valid && m_act != 0) begin
        int a;
        logic [7:0] oldv, lk, v;
        bit we, bad;
        a    = (m_base & 'h70) | ((m_base + m_idx) & 'hF);
        oldv = mem[a];
        lk   = mem[a & 'h78];
        v    = byte_data;
        we   = 0; bad = 0;
        if (m_allow == 0) bad = 1;
        else if (m_mode == 0) we = 1;
        else if (m_mode == 2) begin we = 1; v = oldv & byte_data; end
        else if (m_mode == 3) bad = 1;
        else if (m_idx == 0) begin
          if ((a & 7) == 0) begin
            if (oldv[0]) begin we = 1; v = oldv & byte_data; end else bad = 1;
          end else if (lk[a & 7]) we = 1;
          else bad = 1;
        end
        if (we) begin exp_en = 1; exp_a = a; exp_d = v; mem[a] <= v; end
        if (bad) exp_rej = 1;
        if (m_idx == m_len) m_act = 0;
        m_idx++;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ok;
      ok = (wr_en === exp_en) && (reject === exp_rej);
      if (exp_en && ok) ok = (wr_addr === exp_a[6:0]) && (wr_data === exp_d);
      n_cmp++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: en=%0b addr=%h data=%h rej=%0b expected en=%0b addr=%h data=%h rej=%0b",
                 tag, wr_en, wr_addr, wr_data, reject, exp_en, exp_a[6:0], exp_d, exp_rej);
      end
    end
  end

  task automatic req(input logic [6:0] a, input logic [3:0] l, input logic [1:0] m,
                     input bit al, input int n, input logic [7:0] d0, input bit overlap);
    @(negedge clk);
    cmd_start = 1; cmd_addr = a; cmd_len = l; cmd_mode = m; cmd_allow = al;
    byte_valid = overlap; byte_data = 8'hEE;
    @(negedge clk);
    cmd_start = 0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1; byte_data = d0 + 8'(k * 8'h11);
      @(negedge clk);
    end
    byte_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_start = 0; cmd_addr = 0; cmd_len = 0; cmd_mode = 0;
    cmd_allow = 0; byte_valid = 0; byte_data = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    n_cmp++;
    if (wr_en !== 1'b0 || reject !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: en=%0b rej=%0b expected 0 0", wr_en, reject);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    tag = "R2"; req(7'h0E, 4'd3, 2'd0, 1, 6, 8'h10, 0);   // wrap 0E,0F,00,01 then extras
    tag = "R2"; req(7'h10, 4'd15, 2'd0, 1, 16, 8'h01, 0); // full page
    tag = "R3"; req(7'h03, 4'd2, 2'd0, 0, 3, 8'h55, 0);
    tag = "R4"; req(7'h60, 4'd1, 2'd3, 1, 2, 8'h00, 0);
    tag = "R5"; req(7'h20, 4'd3, 2'd2, 1, 4, 8'hF3, 0);
    tag = "R5"; req(7'h20, 4'd3, 2'd2, 1, 4, 8'h3C, 0);
    tag = "R2"; req(7'h40, 4'd0, 2'd0, 1, 1, 8'hD9, 0);   // lock byte: offsets 1,2,5 locked
    tag = "R7"; req(7'h41, 4'd0, 2'd1, 1, 1, 8'hA1, 0);   // locked -> reject
    tag = "R7"; req(7'h43, 4'd0, 2'd1, 1, 1, 8'hA3, 0);   // unlocked -> write
    tag = "R6"; req(7'h43, 4'd3, 2'd1, 1, 4, 8'h07, 0);   // only first byte
    tag = "R7"; req(7'h45, 4'd0, 2'd1, 1, 1, 8'h99, 0);
    tag = "R8"; req(7'h40, 4'd0, 2'd1, 1, 1, 8'hF0, 0);   // D9 & F0 = D0, bit0 now 0
    tag = "R8"; req(7'h40, 4'd0, 2'd1, 1, 1, 8'hFF, 0);   // refused
    tag = "R9"; req(7'h50, 4'd1, 2'd0, 1, 2, 8'h42, 1);   // overlapping byte ignored, reject cleared
    tag = "R9"; req(7'h30, 4'd0, 2'd1, 0, 1, 8'h11, 0);
    tag = "R9"; req(7'h31, 4'd0, 2'd0, 1, 1, 8'h12, 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule